// File: doc/BRIEF.md
# Integer Add, Reverse-Subtract and Compare Unit

This unit is the addition path of a 32-bit RISC execute stage. Each cycle in which an instruction is issued, it decodes the 6-bit major opcode and the 11-bit function field and returns the 32-bit result. It also returns the value the carry flag should take next and a strobe telling the flag register whether to take it. The opcode bits act as independent switches. One picks reverse subtraction (second operand minus first). One feeds the current carry flag in as carry-in. One leaves the carry flag untouched. One swaps the second register operand for a 16-bit immediate taken from the instruction word. With one opcode/function pairing, the subtraction becomes a signed or unsigned comparison, and the result's top bit holds the less-than outcome.

A separate prefix instruction can supply the upper 16 bits of the next immediate. The unit holds that half in a one-entry latch. The next issued instruction consumes the latch. If that instruction has the immediate form, the held half replaces the sign extension. The result and the carry outputs are combinational in the issued instruction. The prefix latch is the only state.

Instruction bits are numbered from the top in this text: bit 0 is `instr[31]`. The major opcode is `instr[31:26]`, the immediate is `instr[15:0]` and the function field is `instr[10:0]`.

Top module: `addsub_cmp_unit`

## Requirements
- R1: With `issue_vld` low, or with an opcode whose two upper bits are not 00, `res_vld` and `carry_we` are 0, `result` is 0 and `carry_next` equals `carry_in`; opcodes 0 to 15 with `issue_vld` high raise `res_vld`.
- R2: Opcode bit `instr[26]` set selects reverse subtraction, computing B + ~A + 1 (B minus A); when clear the unit computes A + B.
- R3: Opcode bit `instr[27]` set replaces the implicit carry-in (1 for subtraction, 0 for addition) with `carry_in`.
- R4: Opcode bit `instr[28]` clear gives `carry_we` = 1 and `carry_next` = carry-out of the 32-bit addition; set gives `carry_we` = 0 and `carry_next` = `carry_in`.
- R5: Opcode bit `instr[29]` set makes B equal to `instr[15:0]` sign-extended to 32 bits; clear makes B equal to `opb`. A is always `opa`.
- R6: An issued prefix (opcode 101100) stores `instr[15:0]`. When the next issued instruction has the immediate form, its B is {stored half, `instr[15:0]`}. The prefix produces no result and no carry write.
- R7: Any issued instruction consumes a held prefix, whatever its kind. Cycles with `issue_vld` low leave the held prefix in place.
- R8: Opcode 000101 with function 00000000001 yields B minus A with bit 31 replaced by 1 when B < A as signed numbers and 0 otherwise.
- R9: Opcode 000101 with function 00000000011 does the same with an unsigned comparison.
- R10: Both compares leave the carry flag alone (`carry_we` = 0).
- R11: Synchronous active-low reset discards any held prefix.
- R12: The function field is ignored except for the two compare codes on opcode 000101; any other value there gives a plain reverse subtraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_vld | input | 1 | An instruction is issued this cycle |
| instr | input | 32 | Instruction word, opcode in the top six bits |
| opa | input | 32 | First register operand (A) |
| opb | input | 32 | Second register operand (B, register form) |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Sum, difference or compare result |
| carry_next | output | 1 | Next value of the carry flag |
| carry_we | output | 1 | Carry flag write strobe |
| res_vld | output | 1 | Result belongs to an instruction of this unit |

## Verification
The only state is the prefix latch. A latch that is stale, lost or never loaded shows up as a wrong upper half on the first immediate-form result after a prefix. It can also show up one instruction later, as a held half where sign extension was due. Either way the error reaches the ports within two issued instructions. Everything else is combinational, so a decode or adder fault corrupts `result`, `carry_next` or `carry_we` in the same cycle the instruction is issued. The stimulus therefore puts prefixes, idle gaps, resets and all sixteen opcodes in random order. Compare operands are concentrated on the sign-boundary values.

// File: rtl/addcmp_pkg.sv
// Package: shared widths, opcode constants and the decoded control word
// for the add / reverse-subtract / compare unit.
package addcmp_pkg;

    localparam int IMM_W  = 16;
    localparam int XLEN   = 2 * IMM_W;
    localparam int OPC_W  = 6;
    localparam int FN_W   = 11;

    localparam logic [OPC_W-1:0] OPC_PREFIX  = 6'b101100;
    localparam logic [OPC_W-1:0] OPC_CMP     = 6'b000101;
    localparam logic [FN_W-1:0]  FN_CMP_SGN  = 11'd1;
    localparam logic [FN_W-1:0]  FN_CMP_UNS  = 11'd3;

    // Decoded control for one issued instruction.
    typedef struct packed {
        logic hit;       // instruction belongs to this unit
        logic sub;       // reverse subtract (B + ~A + cin)
        logic use_c;     // carry flag is the carry-in
        logic keep;      // carry flag is not written
        logic imm_form;  // B comes from the immediate path
        logic cmp_en;    // compare: overwrite result MSB
        logic cmp_uns;   // compare is unsigned
        logic pfx;       // immediate prefix instruction
    } addcmp_ctl_t;

endpackage

// File: rtl/addcmp_decode.sv
// Module: addcmp_decode
// Turns the major opcode and function field into the control word.
// Assumes the instruction is qualified by issue_vld; with issue_vld low
// every control bit that causes an effect is forced low.
module addcmp_decode
    import addcmp_pkg::*;
(
    input  logic             issue_vld,
    input  logic [OPC_W-1:0] opcode,
    input  logic [FN_W-1:0]  func,
    output addcmp_ctl_t      ctl
);

    logic in_range;
    logic cmp_code;

    // Range check and compare function match.
    always_comb begin
        in_range = (opcode[OPC_W-1:OPC_W-2] == 2'b00);
        cmp_code = (opcode == OPC_CMP) &&
                   ((func == FN_CMP_SGN) || (func == FN_CMP_UNS));
    end

    // Control word assembly: each opcode bit is an independent switch.
    always_comb begin
        ctl          = '0;
        ctl.hit      = issue_vld && in_range;
        ctl.sub      = opcode[0];
        ctl.use_c    = opcode[1];
        ctl.keep     = opcode[2];
        ctl.imm_form = opcode[3];
        ctl.cmp_en   = issue_vld && in_range && cmp_code;
        ctl.cmp_uns  = func[1];
        ctl.pfx      = issue_vld && (opcode == OPC_PREFIX);
    end

endmodule

// File: rtl/addcmp_operand.sv
// Module: addcmp_operand
// Chooses the second operand B: the register value, or the 16-bit
// immediate widened by sign extension or by a held prefix half.
// Holds the one-entry prefix latch; any issued instruction consumes it,
// idle cycles keep it.
module addcmp_operand
    import addcmp_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_vld,
    input  addcmp_ctl_t   ctl,
    input  logic [IW-1:0] imm,
    input  logic [W-1:0]  opb,
    output logic [W-1:0]  b_eff
);

    localparam int UPPER_W = W - IW;

    logic               pfx_vld;
    logic [UPPER_W-1:0] pfx_hi;
    logic [UPPER_W-1:0] upper;

    // Prefix latch: load on a prefix, drop on any other issued instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pfx_vld <= 1'b0;
            pfx_hi  <= '0;
        end else if (issue_vld) begin
            pfx_vld <= ctl.pfx;
            if (ctl.pfx) pfx_hi <= imm[UPPER_W-1:0];
        end
    end

    // Upper-half source and B operand selection.
    always_comb begin
        upper = pfx_vld ? pfx_hi : {UPPER_W{imm[IW-1]}};
        b_eff = ctl.imm_form ? {upper, imm} : opb;
    end

    // R6
    pfx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && ctl.pfx) |=> (pfx_vld && pfx_hi == $past(imm[UPPER_W-1:0])));

    // R7
    pfx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && !ctl.pfx) |=> !pfx_vld);

    // R7
    pfx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |=> ($stable(pfx_vld) && $stable(pfx_hi)));

endmodule

// File: rtl/addcmp_core.sv
// Module: addcmp_core
// Single carry-propagate adder shared by add, reverse subtract and
// compare. The compare outcome comes from the adder's own sign and
// carry bits, so no second comparator is built.
module addcmp_core #(
    parameter int W = 32
) (
    input  logic         sub,
    input  logic         use_c,
    input  logic         carry_in,
    input  logic         cmp_en,
    input  logic         cmp_uns,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         cout
);

    localparam int MSB = W - 1;

    logic [W-1:0] a_x;
    logic         cin;
    logic [W:0]   sum;
    logic         lt_sgn;
    logic         lt_uns;
    logic         lt;

    // Operand conditioning and carry-in choice.
    always_comb begin
        a_x = sub ? ~a : a;
        cin = use_c ? carry_in : sub;
    end

    // The adder itself.
    always_comb begin
        sum  = {1'b0, b} + {1'b0, a_x} + {{W{1'b0}}, cin};
        cout = sum[W];
    end

    // Less-than from sign bits and borrow (valid when sub=1, cin=1).
    always_comb begin
        lt_sgn = (a[MSB] ^ b[MSB]) ? b[MSB] : sum[MSB];
        lt_uns = ~sum[W];
        lt     = cmp_uns ? lt_uns : lt_sgn;
    end

    // Result: compare overwrites only the top bit.
    always_comb begin
        res = sum[W-1:0];
        if (cmp_en) res[MSB] = lt;
    end

endmodule

// File: rtl/addsub_cmp_unit.sv
// Module: addsub_cmp_unit (top)
// Integer add / reverse subtract / compare unit with carry-flag update
// and immediate prefix merging. Result and carry outputs are
// combinational in the issued instruction; the prefix latch is the only
// state. Instruction fields: opcode instr[31:26], imm instr[15:0],
// function instr[10:0].
module addsub_cmp_unit
    import addcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue_vld,
    input  logic [31:0] instr,
    input  logic [31:0] opa,
    input  logic [31:0] opb,
    input  logic        carry_in,
    output logic [31:0] result,
    output logic        carry_next,
    output logic        carry_we,
    output logic        res_vld
);

    addcmp_ctl_t      ctl;
    logic [XLEN-1:0]  b_eff;
    logic [XLEN-1:0]  core_res;
    logic             core_cout;

    addcmp_decode u_dec (
        .issue_vld (issue_vld),
        .opcode    (instr[31:26]),
        .func      (instr[10:0]),
        .ctl       (ctl)
    );

    addcmp_operand #(.W(XLEN), .IW(IMM_W)) u_opnd (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_vld (issue_vld),
        .ctl       (ctl),
        .imm       (instr[IMM_W-1:0]),
        .opb       (opb),
        .b_eff     (b_eff)
    );

    addcmp_core #(.W(XLEN)) u_core (
        .sub      (ctl.sub),
        .use_c    (ctl.use_c),
        .carry_in (carry_in),
        .cmp_en   (ctl.cmp_en),
        .cmp_uns  (ctl.cmp_uns),
        .a        (opa),
        .b        (b_eff),
        .res      (core_res),
        .cout     (core_cout)
    );

    // Output gating and carry flag update.
    always_comb begin
        res_vld    = ctl.hit;
        carry_we   = ctl.hit && !ctl.keep;
        carry_next = carry_we ? core_cout : carry_in;
        result     = ctl.hit ? core_res : '0;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_vld |-> (!res_vld && !carry_we && carry_next == carry_in));

    // R4
    keep_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && instr[28]) |-> !carry_we);

    // R2
    rsub_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && instr[26] && !instr[27] && !instr[29] &&
         !(instr[31:26] == OPC_CMP &&
           (instr[10:0] == FN_CMP_SGN || instr[10:0] == FN_CMP_UNS)))
        |-> (result == opb - opa));

    // R8
    cmp_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && instr[31:26] == OPC_CMP && instr[10:0] == FN_CMP_SGN)
        |-> (result[31] == ($signed(opb) < $signed(opa)) &&
             result[30:0] == (opb[30:0] - opa[30:0])));

    // R9
    cmp_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && instr[31:26] == OPC_CMP && instr[10:0] == FN_CMP_UNS)
        |-> (result[31] == (opb < opa)));

    // R10
    cmp_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && instr[31:26] == OPC_CMP &&
         (instr[10:0] == FN_CMP_SGN || instr[10:0] == FN_CMP_UNS))
        |-> (!carry_we && carry_next == carry_in));

endmodule

// File: tb/addsub_cmp_unit_test.sv
module addsub_cmp_unit_test;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_vld = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        carry_next;
    logic        carry_we;
    logic        res_vld;

    int total = 0;
    int bad = 0;

    // bench-side prefix state
    logic        m_pv = 1'b0;
    logic [15:0] m_ph = '0;

    always #(CLK_P/2) clk = ~clk;

    addsub_cmp_unit uut (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .instr(instr),
        .opa(opa), .opb(opb), .carry_in(carry_in), .result(result),
        .carry_next(carry_next), .carry_we(carry_we), .res_vld(res_vld)
    );

    function automatic logic [31:0] enc_r(input logic [5:0] op, input logic [10:0] fn);
        return {op, 5'd3, 5'd1, 5'd2, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [15:0] imm);
        return {op, 5'd3, 5'd1, imm};
    endfunction

    // Expected {res_vld, carry_we, carry_next, result} from the requirements.
    function automatic logic [34:0] model(input logic iv, input logic [31:0] ins,
                                          input logic [31:0] a, input logic [31:0] b,
                                          input logic ci, input logic pv,
                                          input logic [15:0] ph);
        logic [5:0]  op;
        logic [10:0] fn;
        logic [31:0] bb;
        logic [31:0] ax;
        logic        c0;
        logic [32:0] s;
        logic [31:0] r;
        logic        we;
        op = ins[31:26];
        fn = ins[10:0];
        if (!iv || op[5:4] != 2'b00) return {1'b0, 1'b0, ci, 32'h0};   // R1
        if (op[3]) bb = pv ? {ph, ins[15:0]} : {{16{ins[15]}}, ins[15:0]}; // R5 R6
        else       bb = b;
        ax = op[0] ? ~a : a;                                           // R2
        c0 = op[1] ? ci : op[0];                                       // R3
        s  = {1'b0, bb} + {1'b0, ax} + {32'h0, c0};
        r  = s[31:0];
        if (op == 6'b000101 && fn == 11'd1) r[31] = ($signed(bb) < $signed(a)); // R8
        if (op == 6'b000101 && fn == 11'd3) r[31] = (bb < a);                   // R9
        we = !op[2];                                                   // R4 R10
        return {1'b1, we, (we ? s[32] : ci), r};
    endfunction

    task automatic step(input logic iv, input logic [31:0] ins, input logic [31:0] a,
                        input logic [31:0] b, input logic ci, input string tag);
        logic [34:0] exp;
        logic [34:0] got;
        @(negedge clk);
        issue_vld = iv; instr = ins; opa = a; opb = b; carry_in = ci;
        #5;
        exp = model(iv, ins, a, b, ci, m_pv, m_ph);
        got = {res_vld, carry_we, carry_next, result};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: ins=%h a=%h b=%h ci=%0d got vld=%0d we=%0d c=%0d res=%h exp vld=%0d we=%0d c=%0d res=%h",
                     tag, ins, a, b, ci, got[34], got[33], got[32], got[31:0],
                     exp[34], exp[33], exp[32], exp[31:0]);
        end
        if (iv) begin
            if (ins[31:26] == 6'b101100) begin m_pv = 1'b1; m_ph = ins[15:0]; end
            else m_pv = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; issue_vld = 1'b0;
        #5;
        total++;
        if (res_vld !== 1'b0 || carry_we !== 1'b0) begin
            bad++;
            $display("FAIL R1 reset: got vld=%0d we=%0d exp vld=0 we=0", res_vld, carry_we);
        end
        @(negedge clk);
        rst_n = 1'b1;
        m_pv = 1'b0;
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'h8000_0000;
            2: return 32'hFFFF_FFFF;
            3: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    function automatic string tag_of(input logic [31:0] ins);
        logic [5:0] op;
        op = ins[31:26];
        if (op == 6'b101100) return "R6 prefix";
        if (op[5:4] != 2'b00) return "R1 foreign";
        if (op == 6'b000101 && ins[10:0] == 11'd1) return "R8 cmp signed";
        if (op == 6'b000101 && ins[10:0] == 11'd3) return "R9 cmp unsigned";
        if (op[3]) return "R5 immediate";
        return "R2 R3 R4 R12 arith";
    endfunction

    // watchdog
    initial begin
        #(CLK_P * 200000);
        bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        do_reset();                                                       // R1 R11

        step(1'b0, enc_r(6'b000000, 11'd0), 32'd7, 32'd9, 1'b1, "R1 idle");
        step(1'b1, enc_r(6'b100000, 11'd0), 32'd7, 32'd9, 1'b0, "R1 foreign opcode");
        step(1'b1, enc_r(6'b000101, 11'd0), 32'd3, 32'd10, 1'b0, "R2 rsubk");
        step(1'b1, enc_r(6'b000000, 11'd0), 32'hFFFF_FFFF, 32'd1, 1'b0, "R4 add carry out");
        step(1'b1, enc_r(6'b000010, 11'd0), 32'd5, 32'd6, 1'b1, "R3 addc");
        step(1'b1, enc_r(6'b000011, 11'd0), 32'd5, 32'd6, 1'b0, "R3 rsubc");
        step(1'b1, enc_r(6'b000100, 11'd0), 32'hFFFF_FFFF, 32'd1, 1'b0, "R4 keep");
        step(1'b1, enc_i(6'b001100, 16'hFFFF), 32'd5, 32'h0, 1'b0, "R5 sext imm");
        step(1'b1, enc_i(6'b101100, 16'h1234), 32'd0, 32'd0, 1'b1, "R6 prefix load");
        step(1'b1, enc_i(6'b001100, 16'h5678), 32'd0, 32'd0, 1'b0, "R6 merged imm");
        step(1'b1, enc_i(6'b001100, 16'h8000), 32'd0, 32'd0, 1'b0, "R7 consumed");
        step(1'b1, enc_i(6'b101100, 16'hABCD), 32'd0, 32'd0, 1'b0, "R6 prefix load");
        step(1'b0, enc_i(6'b001100, 16'h0001), 32'd0, 32'd0, 1'b0, "R7 idle gap");
        step(1'b1, enc_i(6'b001000, 16'h8001), 32'd1, 32'd0, 1'b0, "R7 held over idle");
        step(1'b1, enc_i(6'b101100, 16'h7777), 32'd0, 32'd0, 1'b0, "R6 prefix load");
        step(1'b1, enc_r(6'b000000, 11'd0), 32'd1, 32'd2, 1'b0, "R7 consumed by reg form");
        step(1'b1, enc_i(6'b001100, 16'h9000), 32'd0, 32'd0, 1'b0, "R7 sext after consume");
        step(1'b1, enc_i(6'b101100, 16'h4444), 32'd0, 32'd0, 1'b0, "R6 prefix load");
        do_reset();
        step(1'b1, enc_i(6'b001100, 16'h8000), 32'd0, 32'd0, 1'b0, "R11 reset drops prefix");
        step(1'b1, enc_r(6'b000101, 11'd1), 32'h7FFF_FFFF, 32'h8000_0000, 1'b1, "R8 cmp signed lt");
        step(1'b1, enc_r(6'b000101, 11'd1), 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, "R8 cmp signed ge");
        step(1'b1, enc_r(6'b000101, 11'd1), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R8 cmp equal");
        step(1'b1, enc_r(6'b000101, 11'd3), 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, "R9 cmp unsigned ge");
        step(1'b1, enc_r(6'b000101, 11'd3), 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, "R9 cmp unsigned lt");
        step(1'b1, enc_r(6'b000101, 11'd3), 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R10 cmp keeps carry");
        step(1'b1, enc_r(6'b000101, 11'd2), 32'h8000_0000, 32'h7FFF_FFFF, 1'b0, "R12 other func");
        step(1'b1, enc_r(6'b000000, 11'h7FF), 32'd4, 32'd5, 1'b0, "R12 func ignored");

        for (int i = 0; i < 3000; i++) begin
            int unsigned k;
            logic [31:0] ins;
            logic [5:0]  op;
            logic [10:0] fn;
            logic        iv;
            k  = $urandom % 16;
            iv = 1'b1;
            op = 6'($urandom % 16);
            fn = ($urandom % 2 == 0) ? 11'd0 : 11'($urandom);
            if (op == 6'b000101) begin
                case ($urandom % 4)
                    0: fn = 11'd1;
                    1: fn = 11'd3;
                    default: ;
                endcase
            end
            ins = op[3] ? enc_i(op, 16'($urandom)) : enc_r(op, fn);
            if (k == 11 || k == 12) ins = enc_i(6'b101100, 16'($urandom));
            if (k == 13) iv = 1'b0;
            if (k == 14) ins = {6'($urandom % 48 + 16), 26'($urandom)};
            if (k == 15) ins = enc_r(6'b000101, ($urandom % 2 == 0) ? 11'd1 : 11'd3);
            step(iv, ins, pick_val(), pick_val(), 1'($urandom), tag_of(ins));
            if (i == 1500) do_reset();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule